// File: doc/BRIEF.md
# Bidirectional Registered Mailbox Port with Parity and Flags

This block links two 8-bit buses, A and B, through two independent holding registers, one for each direction. A producer stores a byte by raising a load strobe while that direction's active-low capture enable is low. The store raises a "data waiting" flag. The consumer on the far side pulls that direction's active-low read enable low to drive the stored byte onto its bus. When it lets the enable go high again, the flag clears. The two sides can therefore pass bytes as a demand-response mailbox, with no shared handshake logic outside the block.

Bytes going from A to B get a generated parity bit, which is driven beside the byte. Bytes going from B to A are stored with a parity bit that arrives from the B side. While the A side reads, the nine stored bits are checked and an active-low error line reports any mismatch. Every strobe and enable is sampled on one system clock, and edges are found by comparing each sample with the previous one. The reset is synchronous and active low. Each three-state pin group is given as a data output plus a drive enable.

Top module: `mbx_port`

## Requirements
- R1: On a clock edge where `ab_load` is sampled high after being low in the previous sample, and `ab_cap_n` is low, the A-to-B register takes `a_in`. On every other edge it keeps its contents, and a high `ab_cap_n` blocks the load.
- R2: Under the same edge rule, `ba_load` with `ba_cap_n` low stores `b_in` in the B-to-A register and `par_in` in a one-bit parity register on the same clock edge.
- R3: A load of a direction sets that direction's flag (`ab_full` or `ba_full`). The flag reads high from the clock edge that performs the load.
- R4: A flag clears on the clock edge that samples its read enable (`ab_rd_n` or `ba_rd_n`) high after a low sample. With no such edge and no load, the flag holds.
- R5: If a load and a clear reach the same flag on one edge, the flag ends up set.
- R6: `b_oe` and `par_oe` are high exactly while `ab_rd_n` is low, in the same cycle, with no clock delay. While driving, `b_out` equals the A-to-B register. While not driving, `b_out` and `par_out` are zero.
- R7: `a_oe` is high exactly while `ba_rd_n` is low, in the same cycle. While driving, `a_out` equals the B-to-A register. While not driving, `a_out` is zero.
- R8: While driving, `par_out` is 1 when the A-to-B register holds an even number of ones, including zero ones, and 0 when the count is odd.
- R9: With `ba_rd_n` low, `err_n` is 1 when the eight stored B-to-A bits together with the stored parity bit contain an odd number of ones. It is 0 (error) when that total is even.
- R10: With `ba_rd_n` high, `err_n` is 1 whatever the stored contents.
- R11: While `rst_n` is low, no output drives and `err_n` is 1. After reset, both flags and both registers are zero, including the stored parity bit.
- R12: A load strobe held high for several cycles loads only once, at its first high sample. Later changes on the data input do not reach the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 8 | A-bus byte offered for the A-to-B direction |
| ab_load | input | 1 | A-to-B load strobe, acts on its rising edge |
| ab_cap_n | input | 1 | A-to-B capture enable, active low |
| ab_rd_n | input | 1 | B-side read enable, active low; its rising edge clears `ab_full` |
| b_out | output | 8 | Byte driven onto the B bus |
| b_oe | output | 1 | Drive enable for `b_out` |
| par_out | output | 1 | Generated parity for the B bus |
| par_oe | output | 1 | Drive enable for `par_out` |
| ab_full | output | 1 | A-to-B data-waiting flag |
| b_in | input | 8 | B-bus byte offered for the B-to-A direction |
| par_in | input | 1 | Parity bit that comes in with `b_in` |
| ba_load | input | 1 | B-to-A load strobe, acts on its rising edge |
| ba_cap_n | input | 1 | B-to-A capture enable, active low |
| ba_rd_n | input | 1 | A-side read enable, active low; its rising edge clears `ba_full` |
| a_out | output | 8 | Byte driven onto the A bus |
| a_oe | output | 1 | Drive enable for `a_out` |
| err_n | output | 1 | Parity check result, active low |
| ba_full | output | 1 | B-to-A data-waiting flag |

## Verification
A corrupted register or stored parity bit is not visible on the outputs while its read enable is high. It shows up in the same cycle that enable goes low: as a wrong byte, as a wrong `par_out`, or as `err_n` taking the wrong level. A flag that is stuck, or that was set or cleared at the wrong time, is visible on `ab_full` or `ba_full` one clock after the faulty edge. An edge detector that has lost its previous sample reveals itself when a strobe is held high and loads a second time. The bench therefore reads back after every store, and it holds strobes high while the data input changes.

// File: rtl/mbx_pkg.sv
// Package: shared indices for the mailbox port's sampled control strobes.
// Assumes the strobe vector is assembled in the order given here.
package mbx_pkg;
    localparam int N_STRB = 4;
    localparam int IDX_AB_LD = 0;
    localparam int IDX_AB_RD = 1;
    localparam int IDX_BA_LD = 2;
    localparam int IDX_BA_RD = 3;
endpackage

// File: rtl/mbx_edge_det.sv
// Module: rising-edge detector for one sampled control input.
// Keeps the previous sample and reports a one-cycle pulse when the
// current input is high and the previous sample was low. The reset
// value of the sample is a parameter so that reset never fakes an edge.
module mbx_edge_det #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    logic prev_q;

    // Hold the previous sample of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= sig_in;
    end

    assign rise = sig_in & ~prev_q;

    // R12
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/mbx_lane.sv
// Module: one direction of the mailbox: data register, optional stored
// parity bit, and the data-waiting flag.
// Assumes load_rise and clr_rise are single-cycle pulses from edge
// detectors. When both reach the flag in the same cycle, set wins.
module mbx_lane #(
    parameter int  W       = 8,
    parameter bit  HAS_PAR = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_rise,
    input  logic         cap_n,
    input  logic         clr_rise,
    input  logic [W-1:0] din,
    input  logic         pin,
    output logic [W-1:0] q,
    output logic         pq,
    output logic         flag
);
    logic         load_go;
    logic [W-1:0] q_r;
    logic         flag_r;

    assign load_go = load_rise & ~cap_n;

    // Data register: store on a qualified load, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       q_r <= '0;
        else if (load_go) q_r <= din;
    end

    // Flag: set on load, clear on read-enable release, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_r <= 1'b0;
        else if (load_go)  flag_r <= 1'b1;
        else if (clr_rise) flag_r <= 1'b0;
    end

    generate
        if (HAS_PAR) begin : g_par
            logic pq_r;
            // Stored parity bit, loaded together with the data.
            always_ff @(posedge clk) begin
                if (!rst_n)       pq_r <= 1'b0;
                else if (load_go) pq_r <= pin;
            end
            assign pq = pq_r;

            // R2
            par_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                load_go |=> pq == $past(pin));
        end else begin : g_nopar
            logic unused_pin;
            assign unused_pin = pin;
            assign pq = 1'b0;
        end
    endgenerate

    assign q    = q_r;
    assign flag = flag_r;

    // R1
    data_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_go |=> q == $past(din));
    // R1
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_go |=> $stable(q));
    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_go |=> flag);
    // R4
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rise && !load_go) |=> !flag);
    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_rise && !load_go) |=> $stable(flag));
endmodule

// File: rtl/mbx_port.sv
// Module: top of the two-way mailbox port. It samples the four control
// strobes on clk, runs one lane for each direction, generates parity
// toward B and checks the stored parity toward A.
// Assumes all inputs are synchronous to clk. The drive enables follow
// the read enables combinationally and are held off during reset.
module mbx_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic         ab_load,
    input  logic         ab_cap_n,
    input  logic         ab_rd_n,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic         par_out,
    output logic         par_oe,
    output logic         ab_full,
    input  logic [W-1:0] b_in,
    input  logic         par_in,
    input  logic         ba_load,
    input  logic         ba_cap_n,
    input  logic         ba_rd_n,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic         err_n,
    output logic         ba_full
);
    import mbx_pkg::*;

    logic [N_STRB-1:0] strb;
    logic [N_STRB-1:0] rise;
    logic [W-1:0]      ab_q;
    logic [W-1:0]      ba_q;
    logic              ab_pq_unused;
    logic              ba_pq;
    logic              b_drv;
    logic              a_drv;

    assign strb[IDX_AB_LD] = ab_load;
    assign strb[IDX_AB_RD] = ab_rd_n;
    assign strb[IDX_BA_LD] = ba_load;
    assign strb[IDX_BA_RD] = ba_rd_n;

    generate
        for (genvar i = 0; i < N_STRB; i++) begin : g_edge
            mbx_edge_det #(.RST_VAL(1'b1)) i_edge (
                .clk   (clk),
                .rst_n (rst_n),
                .sig_in(strb[i]),
                .rise  (rise[i])
            );
        end
    endgenerate

    mbx_lane #(.W(W), .HAS_PAR(1'b0)) i_ab_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_rise(rise[IDX_AB_LD]),
        .cap_n    (ab_cap_n),
        .clr_rise (rise[IDX_AB_RD]),
        .din      (a_in),
        .pin      (1'b0),
        .q        (ab_q),
        .pq       (ab_pq_unused),
        .flag     (ab_full)
    );

    mbx_lane #(.W(W), .HAS_PAR(1'b1)) i_ba_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_rise(rise[IDX_BA_LD]),
        .cap_n    (ba_cap_n),
        .clr_rise (rise[IDX_BA_RD]),
        .din      (b_in),
        .pin      (par_in),
        .q        (ba_q),
        .pq       (ba_pq),
        .flag     (ba_full)
    );

    // B-side drive: byte and generated even-count parity.
    always_comb begin
        b_drv   = rst_n & ~ab_rd_n;
        b_oe    = b_drv;
        par_oe  = b_drv;
        b_out   = b_drv ? ab_q : '0;
        par_out = b_drv & ~(^ab_q);
    end

    // A-side drive and parity check over nine stored bits.
    always_comb begin
        a_drv = rst_n & ~ba_rd_n;
        a_oe  = a_drv;
        a_out = a_drv ? ba_q : '0;
        err_n = ~a_drv | (^{ba_q, ba_pq});
    end

    // R6
    par_oe_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe == b_oe);
    // R10
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ba_rd_n |-> err_n);
    // R11
    reset_flags_chk: assert property (@(posedge clk)
        !rst_n |=> (!ab_full && !ba_full));
    // R7
    a_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_oe |-> (a_out == '0));
endmodule

// File: tb/test_mbx_port.sv
module test_mbx_port;
    localparam int W = 8;
    localparam int NV = 8;
    // entry: {a_byte, b_byte, par_bit, exp_par_out, exp_err_n}
    localparam logic [18:0] VEC [NV] = '{
        {8'h00, 8'h00, 1'b0, 1'b1, 1'b0},
        {8'h01, 8'h01, 1'b0, 1'b0, 1'b1},
        {8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1},
        {8'h80, 8'h80, 1'b1, 1'b0, 1'b0},
        {8'h3C, 8'h07, 1'b0, 1'b1, 1'b1},
        {8'hA5, 8'h7F, 1'b0, 1'b1, 1'b1},
        {8'hFE, 8'hFE, 1'b0, 1'b0, 1'b1},
        {8'h55, 8'h55, 1'b0, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic [W-1:0] a_in, b_in, b_out, a_out;
    logic ab_load, ab_cap_n, ab_rd_n, b_oe, par_out, par_oe, ab_full;
    logic par_in, ba_load, ba_cap_n, ba_rd_n, a_oe, err_n, ba_full;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mbx_port #(.W(W)) i_mbx_port (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .ab_load(ab_load),
        .ab_cap_n(ab_cap_n), .ab_rd_n(ab_rd_n), .b_out(b_out), .b_oe(b_oe),
        .par_out(par_out), .par_oe(par_oe), .ab_full(ab_full), .b_in(b_in),
        .par_in(par_in), .ba_load(ba_load), .ba_cap_n(ba_cap_n),
        .ba_rd_n(ba_rd_n), .a_out(a_out), .a_oe(a_oe), .err_n(err_n),
        .ba_full(ba_full)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_ab(input logic [W-1:0] d);
        a_in = d; ab_cap_n = 1'b0; ab_load = 1'b1;
        tick();
        ab_load = 1'b0; ab_cap_n = 1'b1;
        tick();
    endtask

    task automatic load_ba(input logic [W-1:0] d, input logic p);
        b_in = d; par_in = p; ba_cap_n = 1'b0; ba_load = 1'b1;
        tick();
        ba_load = 1'b0; ba_cap_n = 1'b1;
        tick();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; a_in = '0; b_in = '0; par_in = 1'b0;
        ab_load = 1'b0; ab_cap_n = 1'b1; ab_rd_n = 1'b0;
        ba_load = 1'b0; ba_cap_n = 1'b1; ba_rd_n = 1'b0;
        @(negedge clk);
        #1;
        // R11: no drive in reset even with read enables low
        chk("R11 b_oe in reset", b_oe, 0);
        chk("R11 a_oe in reset", a_oe, 0);
        chk("R11 err_n in reset", err_n, 1);
        ab_rd_n = 1'b1; ba_rd_n = 1'b1;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk("R11 ab_full after reset", ab_full, 0);
        chk("R11 ba_full after reset", ba_full, 0);
        ab_rd_n = 1'b0; ba_rd_n = 1'b0;
        #1;
        chk("R11 ab reg zero", b_out, 0);
        chk("R11 ba reg zero", a_out, 0);
        chk("R11 stored parity zero -> even -> err", err_n, 0);
        ab_rd_n = 1'b1; ba_rd_n = 1'b1;
        tick();

        // table walk
        for (int i = 0; i < NV; i++) begin
            load_ab(VEC[i][18:11]);
            load_ba(VEC[i][10:3], VEC[i][2]);
            chk("R3 ab_full set", ab_full, 1);
            chk("R3 ba_full set", ba_full, 1);
            chk("R10 err_n idle", err_n, 1);
            chk("R6 b_out quiet", b_out, 0);
            ab_rd_n = 1'b0; ba_rd_n = 1'b0;
            #1;
            chk("R6 b_oe", b_oe, 1);
            chk("R6 par_oe", par_oe, 1);
            chk("R1 b_out data", b_out, VEC[i][18:11]);
            chk("R8 par_out", par_out, VEC[i][1]);
            chk("R7 a_oe", a_oe, 1);
            chk("R2 a_out data", a_out, VEC[i][10:3]);
            chk("R9 err_n", err_n, VEC[i][0]);
            tick();
            chk("R4 flag held while reading", ab_full, 1);
            ab_rd_n = 1'b1; ba_rd_n = 1'b1;
            #1;
            chk("R7 a_out quiet", a_out, 0);
            chk("R6 par_out quiet", par_out, 0);
            tick();
            chk("R4 ab_full cleared", ab_full, 0);
            chk("R4 ba_full cleared", ba_full, 0);
        end

        // R1: cap_n high blocks load
        a_in = 8'h5A; ab_cap_n = 1'b1; ab_load = 1'b1;
        tick();
        ab_load = 1'b0;
        tick();
        chk("R1 blocked load no flag", ab_full, 0);
        ab_rd_n = 1'b0; #1;
        chk("R1 blocked load keeps data", b_out, 8'h55);
        ab_rd_n = 1'b1;
        tick();

        // R12: held strobe loads only once
        a_in = 8'hC3; ab_cap_n = 1'b0; ab_load = 1'b1;
        tick();
        a_in = 8'h18;
        tick(); tick();
        ab_load = 1'b0; ab_cap_n = 1'b1;
        tick();
        ab_rd_n = 1'b0; #1;
        chk("R12 single load on held strobe", b_out, 8'hC3);
        tick();

        // R5: set and clear on the same edge (ab_rd_n rises with load)
        a_in = 8'h0F; ab_cap_n = 1'b0; ab_load = 1'b1; ab_rd_n = 1'b1;
        tick();
        chk("R5 set wins over clear", ab_full, 1);
        ab_load = 1'b0; ab_cap_n = 1'b1;
        tick();
        chk("R4 flag holds without edge", ab_full, 1);

        // R10: even contents, read enable high -> no error shown
        load_ba(8'h03, 1'b0);
        chk("R10 err_n high when not reading", err_n, 1);
        ba_rd_n = 1'b0; #1;
        chk("R9 even total flags error", err_n, 0);
        ba_rd_n = 1'b1;
        tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule